// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the byte-wide register window through which a host processor programs and services a 16550-style serial controller. The host presents a 3-bit offset together with a read strobe or a write strobe and an 8-bit data byte. The block keeps the configuration registers itself: frame format and bank select, modem control outputs, interrupt enables, FIFO mode and the 16-bit baud divisor. It also returns the received byte, the interrupt identity, the line status and the modem status, which are supplied by neighbouring blocks through ports.

Register accesses that have side effects leave the block as single-cycle pulses, one clock after the strobe: popping the receive FIFO, pushing a byte into the transmit FIFO, and clearing either FIFO. Bit 7 of the line control register acts as a bank switch. While it is set, offsets 0 and 1 reach the two divisor bytes instead of the data and interrupt-enable registers. Several offsets decode to a different register on read than on write. The serial engine, the FIFOs and interrupt prioritisation are outside this block.

Read data is registered. It updates on the clock edge that samples the read strobe and holds its value until the next read.

Top module: `uart_hostregs`

## Requirements
- R1: With line control bit 7 clear, a read returns the following. Offset 0 returns rxData. Offset 1 returns the 4-bit interrupt enable in bits 3:0, with bits 7:4 zero. Offset 3 returns line control unchanged, including bit 7. Offset 4 returns the 5-bit modem control in bits 4:0, with bits 7:5 zero. Offset 5 returns lineStat, offset 6 returns modemStat and offset 7 returns 0x00.
- R2: With line control bit 7 set, reads and writes at offset 0 reach divisor bits 7:0, and reads and writes at offset 1 reach divisor bits 15:8. The interrupt enable and the transmit path are untouched in that case. The divisor is driven on the `divisor` port.
- R3: A read of offset 0 with line control bit 7 clear produces `rxPop` high for exactly one cycle after the strobe. A read of offset 0 with bit 7 set produces no pulse.
- R4: A write of offset 0 with line control bit 7 clear produces `txPush` high for one cycle, with `txData` equal to the written byte. A write of offset 0 with bit 7 set produces no push.
- R5: A write of offset 2 stores bit 0 as `fifoOn` and bit 3 as `dmaMode`. Its bits 7:6 select `rxTrigLevel`: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R6: In a write of offset 2, bit 1 produces a one-cycle `rxClear` pulse and bit 2 produces a one-cycle `txClear` pulse. Neither bit is stored.
- R7: A read of offset 2 returns 11 in bits 7:6 when `fifoOn` is 1 and 00 otherwise. Bits 5:4 are 0 and bits 3:0 are `intIdent`.
- R8: Modem control bit 0 drives `dtr`, bit 1 drives `rts` and bit 3 drives `out2`.
- R9: Writes to offsets 5, 6 and 7 change no register and no output.
- R10: Reset sets interrupt enable, line control, modem control, FIFO mode, the divisor, rdData and all pulses to 0.
- R11: rdData updates only on a clock edge that samples `rdEn` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rxData | input | 8 | Head byte of the receive FIFO |
| intIdent | input | 4 | Pending interrupt code from the prioritiser |
| lineStat | input | 8 | Line status byte |
| modemStat | input | 8 | Modem status byte |
| rxPop | output | 1 | Receive FIFO pop pulse |
| txPush | output | 1 | Transmit FIFO push pulse |
| txData | output | 8 | Byte to push into the transmit FIFO |
| rxClear | output | 1 | Receive FIFO clear pulse |
| txClear | output | 1 | Transmit FIFO clear pulse |
| fifoOn | output | 1 | FIFO mode enabled |
| dmaMode | output | 1 | DMA signalling mode |
| rxTrigLevel | output | 5 | Receive trigger level in bytes |
| lineCtrl | output | 8 | Line control register |
| divisor | output | 16 | Baud divisor |
| intEnable | output | 4 | Interrupt enable bits |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out2 | output | 1 | Master interrupt gate |

## Verification
Properties evaluated on every cycle cover the following. Each pop and push pulse must follow the matching offset-0 access in the bank that allows it. Every clear pulse must trace back to a FIFO control write with its bit set. A divisor-byte write must land in the divisor. The identity readback must track FIFO mode, and read data must hold between reads. Other behaviour needs the bench's access sequences to show. These are the full read map in both banks and the fact that a divisor write leaves the interrupt enable intact. They also include the trigger-level decode, the modem output bits, writes to status offsets being ignored, and a mid-run reset.

// File: rtl/uart_hostregs_pkg.sv
package uart_hostregs_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MDMC = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTS = 3'd6;

  typedef enum logic [3:0] {
    SEL_RX, SEL_IEN, SEL_IDENT, SEL_LINE, SEL_MDMC,
    SEL_LSTS, SEL_MSTS, SEL_DIVLO, SEL_DIVHI, SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   rdStb;
    rdSel_e rdSel;
    logic   popRx;
    logic   pushTx;
    logic   wrDivLo;
    logic   wrDivHi;
    logic   wrIen;
    logic   wrFifo;
    logic   wrLine;
    logic   wrMdmc;
  } regStb_t;
endpackage

// File: rtl/uart_hostregs_ctrl.sv
module uart_hostregs_ctrl
  import uart_hostregs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              bankDiv,
  output regStb_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdStb = rdEn;
    stb.rdSel = SEL_ZERO;
    unique case (addr)
      OFS_DATA: stb.rdSel = bankDiv ? SEL_DIVLO : SEL_RX;
      OFS_IEN:  stb.rdSel = bankDiv ? SEL_DIVHI : SEL_IEN;
      OFS_FIFO: stb.rdSel = SEL_IDENT;
      OFS_LINE: stb.rdSel = SEL_LINE;
      OFS_MDMC: stb.rdSel = SEL_MDMC;
      OFS_LSTS: stb.rdSel = SEL_LSTS;
      OFS_MSTS: stb.rdSel = SEL_MSTS;
      default:  stb.rdSel = SEL_ZERO;
    endcase
    stb.popRx   = rdEn && addr == OFS_DATA && !bankDiv;
    stb.pushTx  = wrEn && addr == OFS_DATA && !bankDiv;
    stb.wrDivLo = wrEn && addr == OFS_DATA && bankDiv;
    stb.wrDivHi = wrEn && addr == OFS_IEN && bankDiv;
    stb.wrIen   = wrEn && addr == OFS_IEN && !bankDiv;
    stb.wrFifo  = wrEn && addr == OFS_FIFO;
    stb.wrLine  = wrEn && addr == OFS_LINE;
    stb.wrMdmc  = wrEn && addr == OFS_MDMC;
  end
endmodule

// File: rtl/uart_hostregs_dp.sv
module uart_hostregs_dp
  import uart_hostregs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IEN_W  = 4,
  parameter int MDMC_W = 5,
  parameter int TRIG_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStb_t             stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [3:0]          intIdent,
  input  logic [DATA_W-1:0]   lineStat,
  input  logic [DATA_W-1:0]   modemStat,
  output logic [DATA_W-1:0]   rdData,
  output logic                rxPop,
  output logic                txPush,
  output logic [DATA_W-1:0]   txData,
  output logic                rxClear,
  output logic                txClear,
  output logic                fifoOn,
  output logic                dmaMode,
  output logic [TRIG_W-1:0]   rxTrigLevel,
  output logic [DATA_W-1:0]   lineCtrl,
  output logic [2*DATA_W-1:0] divisor,
  output logic [IEN_W-1:0]    intEnable,
  output logic [MDMC_W-1:0]   mdmCtrl
);
  localparam int DIV_W = 2 * DATA_W;
  localparam int ID_PAD = DATA_W - 6;

  logic [1:0]        trigCode;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCtrl  <= '0;
      divisor   <= '0;
      intEnable <= '0;
      mdmCtrl   <= '0;
      fifoOn    <= 1'b0;
      dmaMode   <= 1'b0;
      trigCode  <= 2'b00;
      txData    <= '0;
    end else begin
      if (stb.wrLine)  lineCtrl  <= wrData;
      if (stb.wrDivLo) divisor[DATA_W-1:0] <= wrData;
      if (stb.wrDivHi) divisor[DIV_W-1:DATA_W] <= wrData;
      if (stb.wrIen)   intEnable <= wrData[IEN_W-1:0];
      if (stb.wrMdmc)  mdmCtrl   <= wrData[MDMC_W-1:0];
      if (stb.pushTx)  txData    <= wrData;
      if (stb.wrFifo) begin
        fifoOn   <= wrData[0];
        dmaMode  <= wrData[3];
        trigCode <= wrData[DATA_W-1:DATA_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPop   <= 1'b0;
      txPush  <= 1'b0;
      rxClear <= 1'b0;
      txClear <= 1'b0;
    end else begin
      rxPop   <= stb.popRx;
      txPush  <= stb.pushTx;
      rxClear <= stb.wrFifo && wrData[1];
      txClear <= stb.wrFifo && wrData[2];
    end
  end

  always_comb begin
    unique case (trigCode)
      2'd0:    rxTrigLevel = TRIG_W'(1);
      2'd1:    rxTrigLevel = TRIG_W'(4);
      2'd2:    rxTrigLevel = TRIG_W'(8);
      default: rxTrigLevel = TRIG_W'(14);
    endcase
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_RX:    rdNext = rxData;
      SEL_IEN:   rdNext = DATA_W'(intEnable);
      SEL_IDENT: rdNext = {{2{fifoOn}}, {ID_PAD{1'b0}}, intIdent};
      SEL_LINE:  rdNext = lineCtrl;
      SEL_MDMC:  rdNext = DATA_W'(mdmCtrl);
      SEL_LSTS:  rdNext = lineStat;
      SEL_MSTS:  rdNext = modemStat;
      SEL_DIVLO: rdNext = divisor[DATA_W-1:0];
      SEL_DIVHI: rdNext = divisor[DIV_W-1:DATA_W];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uart_hostregs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IEN_W  = 4,
  parameter int MDMC_W = 5,
  parameter int TRIG_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          addr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [3:0]          intIdent,
  input  logic [DATA_W-1:0]   lineStat,
  input  logic [DATA_W-1:0]   modemStat,
  output logic                rxPop,
  output logic                txPush,
  output logic [DATA_W-1:0]   txData,
  output logic                rxClear,
  output logic                txClear,
  output logic                fifoOn,
  output logic                dmaMode,
  output logic [TRIG_W-1:0]   rxTrigLevel,
  output logic [DATA_W-1:0]   lineCtrl,
  output logic [2*DATA_W-1:0] divisor,
  output logic [IEN_W-1:0]    intEnable,
  output logic                dtr,
  output logic                rts,
  output logic                out2
);
  regStb_t           stb;
  logic [MDMC_W-1:0] mdmCtrl;

  uart_hostregs_ctrl ctrl_i (
    .addr    (addr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .bankDiv (lineCtrl[DATA_W-1]),
    .stb     (stb)
  );

  uart_hostregs_dp #(
    .DATA_W (DATA_W),
    .IEN_W  (IEN_W),
    .MDMC_W (MDMC_W),
    .TRIG_W (TRIG_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .rxData      (rxData),
    .intIdent    (intIdent),
    .lineStat    (lineStat),
    .modemStat   (modemStat),
    .rdData      (rdData),
    .rxPop       (rxPop),
    .txPush      (txPush),
    .txData      (txData),
    .rxClear     (rxClear),
    .txClear     (txClear),
    .fifoOn      (fifoOn),
    .dmaMode     (dmaMode),
    .rxTrigLevel (rxTrigLevel),
    .lineCtrl    (lineCtrl),
    .divisor     (divisor),
    .intEnable   (intEnable),
    .mdmCtrl     (mdmCtrl)
  );

  assign dtr  = mdmCtrl[0];
  assign rts  = mdmCtrl[1];
  assign out2 = mdmCtrl[3];
endmodule

// File: rtl/uart_hostregs_chk.sv
module uart_hostregs_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  addr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic        rxPop,
  input logic        txPush,
  input logic [7:0]  txData,
  input logic        rxClear,
  input logic        txClear,
  input logic        fifoOn,
  input logic [7:0]  lineCtrl,
  input logic [15:0] divisor
);
  // R3: an offset-0 read in the data bank pops the receive FIFO next cycle
  p_pop_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0 && !lineCtrl[7]) |=> rxPop);

  // R3: an offset-0 read in the divisor bank never pops
  p_no_pop_div_bank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0 && lineCtrl[7]) |=> !rxPop);

  // R4: a push carries the byte written in the previous cycle
  p_push_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && !lineCtrl[7]) |=> (txPush && txData == $past(wrData)));

  // R6: each clear pulse traces to a FIFO control write with its bit set
  p_rx_clear_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |-> $past(wrEn && addr == 3'd2 && wrData[1]));

  p_tx_clear_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    txClear |-> $past(wrEn && addr == 3'd2 && wrData[2]));

  // R2: divisor low byte follows a write in the divisor bank
  p_div_low_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && lineCtrl[7]) |=> divisor[7:0] == $past(wrData));

  // R7: identity readback top bits mirror FIFO mode
  p_ident_fifo_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && addr == 3'd2) |-> rdData[7:6] == {2{$past(fifoOn)}});

  // R11: read data holds between reads
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> rdData == $past(rdData));
endmodule

bind uart_hostregs uart_hostregs_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .rdEn     (rdEn),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .rxPop    (rxPop),
  .txPush   (txPush),
  .txData   (txData),
  .rxClear  (rxClear),
  .txClear  (txClear),
  .fifoOn   (fifoOn),
  .lineCtrl (lineCtrl),
  .divisor  (divisor)
);

// File: tb/uart_hostregs_tb_top.sv
module uart_hostregs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  rxData = 8'h5A;
  logic [3:0]  intIdent = 4'h2;
  logic [7:0]  lineStat = 8'h60;
  logic [7:0]  modemStat = 8'hB0;
  logic        rxPop, txPush, rxClear, txClear, fifoOn, dmaMode;
  logic [7:0]  txData, lineCtrl;
  logic [4:0]  rxTrigLevel;
  logic [15:0] divisor;
  logic [3:0]  intEnable;
  logic        dtr, rts, out2;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  uart_hostregs dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .rxData(rxData), .intIdent(intIdent),
    .lineStat(lineStat), .modemStat(modemStat), .rxPop(rxPop),
    .txPush(txPush), .txData(txData), .rxClear(rxClear), .txClear(txClear),
    .fifoOn(fifoOn), .dmaMode(dmaMode), .rxTrigLevel(rxTrigLevel),
    .lineCtrl(lineCtrl), .divisor(divisor), .intEnable(intEnable),
    .dtr(dtr), .rts(rts), .out2(out2)
  );

  // Vector layout: [23] write, [22:20] offset, [19:12] data, [11:4] expected read, [3:0] requirement
  localparam int NVEC = 26;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 3'd3, 8'h03, 8'h00, 4'd1},  // R1 frame format
    {1'b0, 3'd3, 8'h00, 8'h03, 4'd1},
    {1'b1, 3'd1, 8'hFF, 8'h00, 4'd1},  // R1 upper enable bits dropped
    {1'b0, 3'd1, 8'h00, 8'h0F, 4'd1},
    {1'b1, 3'd4, 8'hFF, 8'h00, 4'd1},
    {1'b0, 3'd4, 8'h00, 8'h1F, 4'd1},
    {1'b0, 3'd0, 8'h00, 8'h5A, 4'd1},
    {1'b0, 3'd5, 8'h00, 8'h60, 4'd1},
    {1'b0, 3'd6, 8'h00, 8'hB0, 4'd1},
    {1'b0, 3'd7, 8'h00, 8'h00, 4'd1},
    {1'b1, 3'd3, 8'h83, 8'h00, 4'd2},  // R2 divisor bank
    {1'b1, 3'd0, 8'h0C, 8'h00, 4'd2},
    {1'b1, 3'd1, 8'h01, 8'h00, 4'd2},
    {1'b0, 3'd0, 8'h00, 8'h0C, 4'd2},
    {1'b0, 3'd1, 8'h00, 8'h01, 4'd2},
    {1'b0, 3'd3, 8'h00, 8'h83, 4'd2},
    {1'b1, 3'd3, 8'h03, 8'h00, 4'd2},
    {1'b0, 3'd1, 8'h00, 8'h0F, 4'd2},  // R2 enable intact
    {1'b1, 3'd2, 8'hC1, 8'h00, 4'd7},  // R7
    {1'b0, 3'd2, 8'h00, 8'hC2, 4'd7},
    {1'b1, 3'd2, 8'h00, 8'h00, 4'd7},
    {1'b0, 3'd2, 8'h00, 8'h02, 4'd7},
    {1'b1, 3'd5, 8'h00, 8'h00, 4'd9},  // R9 status offsets ignore writes
    {1'b1, 3'd7, 8'hEE, 8'h00, 4'd9},
    {1'b0, 3'd5, 8'h00, 8'h60, 4'd9},
    {1'b0, 3'd7, 8'h00, 8'h00, 4'd9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
    pop = rxPop;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic pop;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rdData", rdData, 0);
    check("R10 lineCtrl", lineCtrl, 0);
    check("R10 divisor", divisor, 0);
    check("R10 fifoOn", fifoOn, 0);
    check("R10 pulses", {rxPop, txPush, rxClear, txClear}, 0);
    check("R10 modem outs", {dtr, rts, out2}, 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][23]) doWrite(VEC[i][22:20], VEC[i][19:12]);
      else begin
        doRead(VEC[i][22:20], rd, pop);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
      end
    end

    // R3 pop pulse, one cycle only
    doRead(3'd0, rd, pop);
    check("R3 pop", pop, 1);
    @(negedge clk);
    check("R3 pop one cycle", rxPop, 0);
    // R11 hold without read
    rxData = 8'h77;
    @(negedge clk);
    check("R11 hold", rdData, 8'h5A);
    doWrite(3'd3, 8'h80);
    doRead(3'd0, rd, pop);
    check("R3 no pop in divisor bank", pop, 0);
    check("R2 read low divisor", rd, 8'h0C);

    // R4 push disabled in divisor bank, low divisor written
    doWrite(3'd0, 8'h34);
    check("R4 no push in divisor bank", txPush, 0);
    check("R2 divisor", divisor, 16'h0134);
    doWrite(3'd3, 8'h00);
    doWrite(3'd0, 8'hA5);
    check("R4 push", txPush, 1);
    check("R4 data", txData, 8'hA5);
    @(negedge clk);
    check("R4 push one cycle", txPush, 0);

    // R6 clear pulses and R5 fields
    doWrite(3'd2, 8'hC7);
    check("R6 clears", {rxClear, txClear}, 2'b11);
    check("R5 enable", fifoOn, 1);
    check("R5 trig 14", rxTrigLevel, 14);
    @(negedge clk);
    check("R6 clears one cycle", {rxClear, txClear}, 2'b00);
    doWrite(3'd2, 8'h0B);
    check("R6 rx only", {rxClear, txClear}, 2'b10);
    check("R5 dma", dmaMode, 1);
    check("R5 trig 1", rxTrigLevel, 1);
    doWrite(3'd2, 8'h40);
    check("R5 trig 4", rxTrigLevel, 4);
    check("R5 dma cleared", dmaMode, 0);
    doWrite(3'd2, 8'h80);
    check("R5 trig 8", rxTrigLevel, 8);

    // R8 modem outputs
    doWrite(3'd4, 8'h0B);
    check("R8 dtr rts out2", {dtr, rts, out2}, 3'b111);
    doWrite(3'd4, 8'h04);
    check("R8 cleared", {dtr, rts, out2}, 3'b000);

    // R9 writes to status offsets leave modem outputs and line control alone
    doWrite(3'd4, 8'h01);
    doWrite(3'd6, 8'hFF);
    check("R9 modem intact", {dtr, rts, out2}, 3'b100);
    check("R9 line intact", lineCtrl, 8'h00);

    // R10 mid-run reset
    doWrite(3'd1, 8'h05);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R10 divisor after reset", divisor, 0);
    check("R10 fifo after reset", fifoOn, 0);
    check("R10 enable after reset", intEnable, 0);
    check("R10 modem after reset", dtr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule